// File: doc/BRIEF.md
# Memory Controller Configuration Register File

This block holds the software-visible configuration and status state of a DRAM controller. Software reaches it through two narrow ports on a local register bus: an index port that selects one internal register, and a data port that reads or writes the register the index points at. Every internal register applies its own write mask. Some registers have side effects on write: error flags clear where a one is written, enable and mode transitions in the configuration word update a read-only status word, and a write to the ECC error status drives an interrupt line.

The block also turns its bank configuration words into address windows. Each bank word gives a base, a size code and an enable. The block compares a presented system address against every window and returns a per-bank hit vector, with at most one bit set. DRAM command sequencing and the data path are not part of this block.

Top module: `memctl_cfg_regs`

## Requirements
- R1: After a synchronous active-low reset, the index reads 0x00000000, configuration reads 0x00800000, refresh reads 0x05F00000, the power timer reads 0x07C00000, status, error address, ECC configuration, ECC error status and all bank words read 0, `ecc_irq` is 0 and `bank_hit` is 0.
- R2: A write to port address `IDX_PORT` (0x10) stores the full 32-bit index, which reads back on that port. Reads from port addresses other than 0x10 and 0x11 return 0, and their writes change nothing.
- R3: Data port (0x11) writes store value AND mask at these indexes: configuration 0x20 (mask 0xFFE00000), refresh 0x30 (0x3FF80000), ECC configuration 0x94 (0x00F00000), ECC error status 0x98 (0xFFF0F000), bank i at 0x40+4*i (0xFFDEE001), and error address 0x10 (all bits). Power timer 0x34 stores (value AND 0xF8000000) OR 0x07C00000.
- R4: Reading index 0x80 (timing) or any index with no register returns 0xFFFFFFFF. Writes to those indexes, and to the read-only status index 0x24, have no effect.
- R5: The error status registers at 0x00 and 0x08 clear each bit written as one. Writes never set a bit, so after reset both read 0 whatever is written.
- R6: When a configuration write turns bit 31 from 0 to 1, status bit 31 becomes 0. When a write turns it from 1 to 0, status bit 31 becomes 1.
- R7: When a configuration write turns bit 30 from 0 to 1, status bit 30 becomes 1. When a write turns it from 1 to 0, status bit 30 becomes 0.
- R8: `ecc_irq` is a register. It is 1 from the edge that stores a nonzero masked ECC error status, and 0 from the edge that stores zero. A written value whose set bits all lie outside the mask stores zero.
- R9: In a bank word, bit 0 is the enable, bits 31:23 give base address bits 31:23, and bits 19:17 are a size code c giving a size of 4 MB << c. A bank hits when `sys_addr` lies in [base, base + size), with no wrap at the top of the 32-bit space.
- R10: No bank hits while configuration bit 31 is 0, while the bank's enable is 0, or while its size code is 7.
- R11: When several banks match, only the lowest-numbered one is reported, so `bank_hit` never has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_wr | input | 1 | Write strobe for the register port |
| acc_addr | input | PORT_AW (10) | Port address: 0x10 is the index port, 0x11 is the data port |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Combinational read data for `acc_addr` |
| sys_addr | input | 32 | System address checked against the bank windows |
| bank_hit | output | NBANK (4) | One-hot-or-zero bank match |
| ecc_irq | output | 1 | Registered ECC error interrupt |

## Verification
The bench builds the block with its default parameters: four banks and a 10-bit port address with the ports at 0x10 and 0x11. With four banks it can place two overlapping windows and show the lower bank winning. It can also put a 256 MB window at base 0xFF800000, which reaches the top of the address space and exercises the window compare without wrap. The two indirect ports bring every mask, the read-all-ones indexes and the status transition rules within reach through normal register accesses.

// File: rtl/memctl_cfg_pkg.sv
// Shared constants for the memory controller configuration register file.
// Assumes a 32-bit register word and 32-bit system addresses.
package memctl_cfg_pkg;
    localparam int WORD_W    = 32;
    localparam int BASE_LSB  = 23;
    localparam int BASE_W    = 9;
    localparam int CODE_LSB  = 17;
    localparam int CODE_W    = 3;
    localparam int UNIT_LOG2 = 22;                 // 4 MB smallest window
    localparam logic [CODE_W-1:0] CODE_BAD = 3'd7;
    localparam int EN_BIT    = 31;                 // global enable in config
    localparam int MODE_BIT  = 30;                 // mode bit mirrored to status

    typedef logic [WORD_W-1:0] word_t;

    // register indexes seen through the data port
    localparam word_t IX_ERR0   = 32'h00;
    localparam word_t IX_ERR1   = 32'h08;
    localparam word_t IX_EADDR  = 32'h10;
    localparam word_t IX_CFG    = 32'h20;
    localparam word_t IX_STAT   = 32'h24;
    localparam word_t IX_RFSH   = 32'h30;
    localparam word_t IX_PTMR   = 32'h34;
    localparam word_t IX_BANK0  = 32'h40;
    localparam word_t IX_ECCCFG = 32'h94;
    localparam word_t IX_ECCERR = 32'h98;

    // write masks
    localparam word_t WM_CFG    = 32'hFFE0_0000;
    localparam word_t WM_RFSH   = 32'h3FF8_0000;
    localparam word_t WM_ECCCFG = 32'h00F0_0000;
    localparam word_t WM_ECCERR = 32'hFFF0_F000;
    localparam word_t WM_BANK   = 32'hFFDE_E001;
    localparam word_t WM_PTMR   = 32'hF800_0000;
    localparam word_t PTMR_ONES = 32'h07C0_0000;

    // reset values
    localparam word_t RV_CFG  = 32'h0080_0000;
    localparam word_t RV_RFSH = 32'h05F0_0000;
    localparam word_t RV_PTMR = 32'h07C0_0000;

    localparam word_t RD_NONE = 32'hFFFF_FFFF;
endpackage

// File: rtl/memctl_bank_win.sv
// One bank address window compare.
// Window is [base, base + (1 << (UNIT_LOG2 + code))), computed one bit wider
// than the address so the top window never wraps. Code CODE_BAD never matches.
module memctl_bank_win
    import memctl_cfg_pkg::*;
(
    input  logic              glb_en,
    input  logic              bk_en,
    input  logic [BASE_W-1:0] base,
    input  logic [CODE_W-1:0] code,
    input  logic [WORD_W-1:0] addr,
    output logic              match
);
    localparam int XW = WORD_W + 1;

    logic [XW-1:0] lo, hi, a_x;

    // Form window bounds and compare the address against them.
    always_comb begin
        lo    = {1'b0, base, {BASE_LSB{1'b0}}};
        hi    = lo + (XW'(1) << (UNIT_LOG2 + int'(code)));
        a_x   = {1'b0, addr};
        match = glb_en && bk_en && (code != CODE_BAD) && (a_x >= lo) && (a_x < hi);
    end
endmodule

// File: rtl/memctl_hit_pick.sv
// Fixed-priority pick: keeps only the lowest set request bit.
// Assumes N >= 1; purely combinational.
module memctl_hit_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    // Walk upward and grant the first request seen.
    always_comb begin
        logic seen;
        seen = 1'b0;
        gnt  = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !seen) begin
                gnt[i] = 1'b1;
                seen   = 1'b1;
            end
        end
    end
endmodule

// File: rtl/memctl_cfg_regs.sv
// Configuration and status register file of a DRAM controller, reached
// through an index port and a data port. It also decodes the bank words into
// address windows and drives a registered ECC error interrupt.
// Assumes NBANK <= 16 so bank indexes stay below the timing index 0x80.
module memctl_cfg_regs
    import memctl_cfg_pkg::*;
#(
    parameter int NBANK = 4,
    parameter int PORT_AW = 10,
    parameter logic [PORT_AW-1:0] IDX_PORT = 10'h010,
    parameter logic [PORT_AW-1:0] DAT_PORT = 10'h011
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_wr,
    input  logic [PORT_AW-1:0] acc_addr,
    input  logic [31:0]        acc_wdata,
    output logic [31:0]        acc_rdata,
    input  logic [31:0]        sys_addr,
    output logic [NBANK-1:0]   bank_hit,
    output logic               ecc_irq
);
    localparam int BANK_STRIDE = 4;

    word_t idx_q, err0_q, err1_q, eaddr_q, cfg_q, stat_q;
    word_t rfsh_q, ptmr_q, ecccfg_q, eccerr_q;
    word_t bank_q [NBANK];

    logic  wr_idx, wr_dat;
    word_t cfg_nxt, eccerr_nxt;
    logic [NBANK-1:0] bank_sel, bank_raw;

    // Decode port writes and the masked next values with side effects.
    always_comb begin
        wr_idx     = acc_wr && (acc_addr == IDX_PORT);
        wr_dat     = acc_wr && (acc_addr == DAT_PORT);
        cfg_nxt    = acc_wdata & WM_CFG;
        eccerr_nxt = acc_wdata & WM_ECCERR;
        for (int i = 0; i < NBANK; i++)
            bank_sel[i] = (idx_q == IX_BANK0 + word_t'(BANK_STRIDE * i));
    end

    // Index register.
    always_ff @(posedge clk) begin
        if (!rst_n)      idx_q <= '0;
        else if (wr_idx) idx_q <= acc_wdata;
    end

    // Plain masked registers and one-to-clear error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err0_q   <= '0;
            err1_q   <= '0;
            eaddr_q  <= '0;
            rfsh_q   <= RV_RFSH;
            ptmr_q   <= RV_PTMR;
            ecccfg_q <= '0;
        end else if (wr_dat) begin
            case (idx_q)
                IX_ERR0:   err0_q   <= err0_q & ~acc_wdata;
                IX_ERR1:   err1_q   <= err1_q & ~acc_wdata;
                IX_EADDR:  eaddr_q  <= acc_wdata;
                IX_RFSH:   rfsh_q   <= acc_wdata & WM_RFSH;
                IX_PTMR:   ptmr_q   <= (acc_wdata & WM_PTMR) | PTMR_ONES;
                IX_ECCCFG: ecccfg_q <= acc_wdata & WM_ECCCFG;
                default: ;
            endcase
        end
    end

    // Configuration word and the status bits its transitions drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= RV_CFG;
            stat_q <= '0;
        end else if (wr_dat && idx_q == IX_CFG) begin
            if (!cfg_q[EN_BIT] && cfg_nxt[EN_BIT])      stat_q[EN_BIT] <= 1'b0;
            else if (cfg_q[EN_BIT] && !cfg_nxt[EN_BIT]) stat_q[EN_BIT] <= 1'b1;
            if (!cfg_q[MODE_BIT] && cfg_nxt[MODE_BIT])      stat_q[MODE_BIT] <= 1'b1;
            else if (cfg_q[MODE_BIT] && !cfg_nxt[MODE_BIT]) stat_q[MODE_BIT] <= 1'b0;
            cfg_q <= cfg_nxt;
        end
    end

    // ECC error status and its registered interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eccerr_q <= '0;
            ecc_irq  <= 1'b0;
        end else if (wr_dat && idx_q == IX_ECCERR) begin
            eccerr_q <= eccerr_nxt;
            ecc_irq  <= |eccerr_nxt;
        end
    end

    // Bank configuration words and their window compares.
    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        always_ff @(posedge clk) begin
            if (!rst_n)                    bank_q[g] <= '0;
            else if (wr_dat && bank_sel[g]) bank_q[g] <= acc_wdata & WM_BANK;
        end

        memctl_bank_win u_win (
            .glb_en (cfg_q[EN_BIT]),
            .bk_en  (bank_q[g][0]),
            .base   (bank_q[g][BASE_LSB +: BASE_W]),
            .code   (bank_q[g][CODE_LSB +: CODE_W]),
            .addr   (sys_addr),
            .match  (bank_raw[g])
        );
    end

    memctl_hit_pick #(.N(NBANK)) u_pick (
        .req (bank_raw),
        .gnt (bank_hit)
    );

    // Read mux for both ports; unknown and timing indexes read all ones.
    always_comb begin
        acc_rdata = '0;
        if (acc_addr == IDX_PORT) begin
            acc_rdata = idx_q;
        end else if (acc_addr == DAT_PORT) begin
            case (idx_q)
                IX_ERR0, IX_ERR1: acc_rdata = (idx_q == IX_ERR0) ? err0_q : err1_q;
                IX_EADDR:  acc_rdata = eaddr_q;
                IX_CFG:    acc_rdata = cfg_q;
                IX_STAT:   acc_rdata = stat_q;
                IX_RFSH:   acc_rdata = rfsh_q;
                IX_PTMR:   acc_rdata = ptmr_q;
                IX_ECCCFG: acc_rdata = ecccfg_q;
                IX_ECCERR: acc_rdata = eccerr_q;
                default:   acc_rdata = RD_NONE;
            endcase
            for (int i = 0; i < NBANK; i++)
                if (bank_sel[i]) acc_rdata = bank_q[i];
        end
    end

    // R3
    rfsh_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dat && idx_q == IX_RFSH) |=> (rfsh_q == ($past(acc_wdata) & WM_RFSH)));

    // R6
    en_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dat && idx_q == IX_CFG && acc_wdata[EN_BIT] && !cfg_q[EN_BIT])
        |=> !stat_q[EN_BIT]);

    // R7
    mode_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dat && idx_q == IX_CFG && acc_wdata[MODE_BIT] && !cfg_q[MODE_BIT])
        |=> stat_q[MODE_BIT]);

    // R8
    ecc_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dat && idx_q == IX_ECCERR)
        |=> (ecc_irq == (($past(acc_wdata) & WM_ECCERR) != '0)));

    // R10
    hit_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_hit != '0) |-> cfg_q[EN_BIT]);

    // R11
    hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_hit));
endmodule

// File: tb/memctl_cfg_regs_tb.sv
// Self-checking bench: a vector table of masked register writes, then
// directed tests for reset, ports, status transitions, interrupt and banks.
module memctl_cfg_regs_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [9:0] PI = 10'h010;
    localparam logic [9:0] PD = 10'h011;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_wr = 1'b0;
    logic [9:0]  acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic [31:0] sys_addr = '0;
    logic [3:0]  bank_hit;
    logic        ecc_irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    memctl_cfg_regs dut_i (
        .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .sys_addr(sys_addr),
        .bank_hit(bank_hit), .ecc_irq(ecc_irq)
    );

    typedef struct packed {
        logic [31:0] idx;
        logic [31:0] wd;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{32'h10, 32'h1234_5678, 32'h1234_5678, 8'd3},  // R3 error address
        '{32'h30, 32'hFFFF_FFFF, 32'h3FF8_0000, 8'd3},  // R3 refresh
        '{32'h34, 32'h0000_0000, 32'h07C0_0000, 8'd3},  // R3 power timer
        '{32'h34, 32'hFFFF_FFFF, 32'hFFC0_0000, 8'd3},  // R3 power timer
        '{32'h94, 32'hFFFF_FFFF, 32'h00F0_0000, 8'd3},  // R3 ECC config
        '{32'h4C, 32'hFFFF_FFFF, 32'hFFDE_E001, 8'd3},  // R3 bank 3
        '{32'h80, 32'h1234_5678, 32'hFFFF_FFFF, 8'd4},  // R4 timing
        '{32'h24, 32'hFFFF_FFFF, 32'h0000_0000, 8'd4},  // R4 status read-only
        '{32'h0C, 32'h0000_0055, 32'hFFFF_FFFF, 8'd4},  // R4 unknown index
        '{32'h00, 32'hFFFF_FFFF, 32'h0000_0000, 8'd5},  // R5 error 0
        '{32'h08, 32'hFFFF_FFFF, 32'h0000_0000, 8'd5}   // R5 error 1
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic port_wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        acc_addr = a; acc_wdata = d; acc_wr = 1'b1;
        @(negedge clk);
        acc_wr = 1'b0;
    endtask

    task automatic port_rd(input logic [9:0] a, output logic [31:0] d);
        acc_addr = a;
        #1 d = acc_rdata;
    endtask

    task automatic reg_wr(input logic [31:0] ix, input logic [31:0] d);
        port_wr(PI, ix);
        port_wr(PD, d);
    endtask

    task automatic reg_rd(input logic [31:0] ix, output logic [31:0] d);
        port_wr(PI, ix);
        port_rd(PD, d);
    endtask

    task automatic hit_at(input logic [31:0] a, input logic [3:0] exp, input string tag);
        sys_addr = a;
        #1 check(tag, {28'd0, bank_hit}, {28'd0, exp});
    endtask

    task automatic finish_run();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog all requirements actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        port_rd(PI, r);          check("R1 index", r, 32'h0);
        check("R1 ecc_irq", {31'd0, ecc_irq}, 32'h0);
        check("R1 bank_hit", {28'd0, bank_hit}, 32'h0);
        reg_rd(32'h20, r);       check("R1 config", r, 32'h0080_0000);
        reg_rd(32'h30, r);       check("R1 refresh", r, 32'h05F0_0000);
        reg_rd(32'h34, r);       check("R1 power timer", r, 32'h07C0_0000);
        reg_rd(32'h24, r);       check("R1 status", r, 32'h0);
        reg_rd(32'h98, r);       check("R1 ecc error", r, 32'h0);
        reg_rd(32'h40, r);       check("R1 bank0", r, 32'h0);

        // R2 index port and unmapped ports
        port_wr(PI, 32'hDEAD_0094);
        port_rd(PI, r);          check("R2 index readback", r, 32'hDEAD_0094);
        port_wr(10'h012, 32'hFFFF_FFFF);
        port_rd(10'h012, r);     check("R2 other port reads zero", r, 32'h0);
        port_rd(PI, r);          check("R2 other port write ignored", r, 32'hDEAD_0094);

        // R3 R4 R5 vector table
        for (int k = 0; k < NV; k++) begin
            reg_wr(VECS[k].idx, VECS[k].wd);
            reg_rd(VECS[k].idx, r);
            check($sformatf("R%0d table row %0d", VECS[k].req, k), r, VECS[k].exp);
        end
        reg_wr(32'h4C, 32'h0);

        // R6 R7 status transitions
        reg_wr(32'h20, 32'hC000_0000);
        reg_rd(32'h24, r);       check("R7 mode rise sets status", r, 32'h4000_0000);
        reg_wr(32'h20, 32'h0000_0000);
        reg_rd(32'h24, r);       check("R6 enable fall sets status", r, 32'h8000_0000);
        reg_wr(32'h20, 32'hFFFF_FFFF);
        reg_rd(32'h20, r);       check("R3 config mask", r, 32'hFFE0_0000);
        reg_rd(32'h24, r);       check("R6 enable rise clears status", r, 32'h4000_0000);
        reg_wr(32'h20, 32'h8000_0000);
        reg_rd(32'h24, r);       check("R7 mode fall clears status", r, 32'h0);

        // R8 ECC interrupt
        reg_wr(32'h98, 32'h000F_0FFF);
        check("R8 masked-off write no irq", {31'd0, ecc_irq}, 32'h0);
        reg_rd(32'h98, r);       check("R8 masked-off stores zero", r, 32'h0);
        reg_wr(32'h98, 32'h0000_1000);
        check("R8 irq rises", {31'd0, ecc_irq}, 32'h1);
        reg_rd(32'h98, r);       check("R3 ecc error mask", r, 32'h0000_1000);
        reg_wr(32'h98, 32'h0);
        check("R8 irq falls", {31'd0, ecc_irq}, 32'h0);

        // R9 R10 R11 bank windows
        reg_wr(32'h40, 32'h0000_0001);   // bank0 4MB at 0
        reg_wr(32'h44, 32'h0104_0001);   // bank1 16MB at 0x01000000
        reg_wr(32'h48, 32'h0100_0001);   // bank2 4MB at 0x01000000
        reg_wr(32'h4C, 32'h100E_0001);   // bank3 code 7
        hit_at(32'h0000_0000, 4'b0001, "R9 bank0 low edge");
        hit_at(32'h003F_FFFF, 4'b0001, "R9 bank0 high edge");
        hit_at(32'h0040_0000, 4'b0000, "R9 bank0 end excluded");
        hit_at(32'h0100_0000, 4'b0010, "R11 overlap lowest wins");
        hit_at(32'h01FF_FFFF, 4'b0010, "R9 bank1 16MB end");
        hit_at(32'h0200_0000, 4'b0000, "R9 past bank1");
        hit_at(32'h1000_0000, 4'b0000, "R10 size code 7");
        reg_wr(32'h44, 32'h0104_0000);
        hit_at(32'h0100_0000, 4'b0100, "R10 disabled bank1 gives bank2");
        reg_wr(32'h40, 32'hFF8C_0001);   // bank0 256MB at 0xFF800000
        hit_at(32'hFFFF_FFFF, 4'b0001, "R9 top window no wrap");
        hit_at(32'h0000_0000, 4'b0000, "R9 moved bank0 no low hit");
        reg_wr(32'h20, 32'h0);
        hit_at(32'hFFFF_FFFF, 4'b0000, "R10 global enable clear");

        finish_run();
    end
endmodule